// File: doc/BRIEF.md
# Legacy Display Cycle Router

This block decides, for every processor-initiated memory or I/O transaction, which of two downstream ports receives it: the graphics port or the hub port. It recognises the legacy colour display resources and the legacy monochrome display resources in both memory and I/O space. It also applies a programmable I/O base/limit window that can be narrowed by an ISA alias filter. Software controls the choice with a display enable bit and a monochrome present bit. The monochrome resources can be sent to the hub port while the colour resources go to the graphics port.

Each I/O request carries a 4-lane byte enable. Each enabled lane is decoded on its own, using only address bits [9:0], so every 1 KB alias of a legacy port matches. If any enabled lane lands on a monochrome location, the whole access goes to the hub port. The block registers one decision per request. The port select and its valid appear on the clock after the request strobe. The block also keeps a sticky flag that records whether the unsupported setting (display enable clear, monochrome present set) has ever been applied.

Top module: `legacy_disp_router`

## Requirements
- R1: `rsp_valid` is high exactly one clock after each cycle in which `req_valid` is high, and low otherwise. `rsp_to_gfx` (1 = graphics port, 0 = hub port) keeps its last value in cycles with no request.
- R2: While `rst_n` is low, `rsp_valid`, `rsp_to_gfx` and `cfg_err` are all 0.
- R3: A memory request in 0B0000h–0B7FFFh goes to the hub when both `cfg_vga_en` and `cfg_mda_present` are set. It goes to the graphics port when only `cfg_vga_en` is set, and to the hub when `cfg_vga_en` is clear.
- R4: A memory request in 0A0000h–0AFFFFh or 0B8000h–0BFFFFh goes to the graphics port when `cfg_vga_en` is set, and to the hub otherwise.
- R5: A memory request outside 0A0000h–0BFFFFh always goes to the hub.
- R6: Lane i of an I/O request addresses byte {req_addr[15:2], i}. The monochrome locations are 3B4h, 3B5h, 3B8h, 3B9h, 3BAh and 3BFh, compared on bits [9:0] only. With both bits set, an I/O request in which any enabled lane hits a monochrome location goes to the hub, even if other lanes hit colour ports.
- R7: With `cfg_vga_en` set, an I/O request in which any enabled lane's bits [9:0] fall in 3BCh–3BFh goes to the hub, whatever the value of `cfg_mda_present`.
- R8: With `cfg_vga_en` set, and no lane caught by R6 or R7, an I/O request with any enabled lane in 3B0h–3BBh or 3C0h–3DFh (bits [9:0]) goes to the graphics port.
- R9: With `cfg_vga_en` clear, an I/O request with any enabled lane in a colour or monochrome location goes to the hub. Any other I/O request, including 3BCh–3BEh, is routed by the window (R10).
- R10: Any other I/O request goes to the graphics port only if {req_addr[15:2],2'b00} lies in `cfg_io_base`..`cfg_io_limit` (inclusive) and is not excluded. It is excluded when `cfg_isa_en` is set and its bits [9:8] are nonzero. Every other such request goes to the hub.
- R11: The setting `cfg_vga_en`=0 with `cfg_mda_present`=1 routes as if both bits were clear. It sets `cfg_err` on the next clock, and `cfg_err` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one per transaction |
| req_is_io | input | 1 | 1 = I/O request, 0 = memory request |
| req_addr | input | 32 | Request address |
| req_be | input | 4 | Byte-lane enables for I/O requests |
| cfg_vga_en | input | 1 | Colour display resources enabled toward graphics port |
| cfg_mda_present | input | 1 | Monochrome resources split to hub port |
| cfg_isa_en | input | 1 | ISA alias filter on the I/O window |
| cfg_io_base | input | 16 | I/O window lower bound |
| cfg_io_limit | input | 16 | I/O window upper bound |
| rsp_valid | output | 1 | Decision valid |
| rsp_to_gfx | output | 1 | 1 = graphics port, 0 = hub port |
| cfg_err | output | 1 | Sticky unsupported-setting flag |

## Verification
Two decodes can claim the same request in one cycle: the whole-access monochrome rule and the colour rule. A dword at 3B4h with all four lanes enabled covers 3B4h/3B5h (monochrome) and 3B6h/3B7h (colour only), and the hub must win. The same dword with only lane 3 enabled must still reach the graphics port. The bench also applies the unsupported setting together with requests, and judges both the hub routing of those requests and the rise and persistence of the error flag.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
  localparam int unsigned ALIAS_W = 10;

  localparam logic [ALIAS_W-1:0] MONO_P0 = 10'h3B4;
  localparam logic [ALIAS_W-1:0] MONO_P1 = 10'h3B5;
  localparam logic [ALIAS_W-1:0] MONO_P2 = 10'h3B8;
  localparam logic [ALIAS_W-1:0] MONO_P3 = 10'h3B9;
  localparam logic [ALIAS_W-1:0] MONO_P4 = 10'h3BA;
  localparam logic [ALIAS_W-1:0] MONO_P5 = 10'h3BF;
  localparam logic [ALIAS_W-1:0] TAIL_LO = 10'h3BC;
  localparam logic [ALIAS_W-1:0] TAIL_HI = 10'h3BF;
  localparam logic [ALIAS_W-1:0] CLR_A_LO = 10'h3B0;
  localparam logic [ALIAS_W-1:0] CLR_A_HI = 10'h3BB;
  localparam logic [ALIAS_W-1:0] CLR_B_LO = 10'h3C0;
  localparam logic [ALIAS_W-1:0] CLR_B_HI = 10'h3DF;

  localparam logic [31:0] FB_LO   = 32'h000A_0000;
  localparam logic [31:0] FB_HI   = 32'h000B_FFFF;
  localparam logic [31:0] MONO_LO = 32'h000B_0000;
  localparam logic [31:0] MONO_HI = 32'h000B_7FFF;

  typedef enum logic {
    PORT_HUB = 1'b0,
    PORT_GFX = 1'b1
  } port_e;

  typedef struct packed {
    logic mono;
    logic tail;
    logic colour;
  } io_hits_t;

  typedef struct packed {
    logic mono;
    logic frame;
  } mem_hits_t;
endpackage

// File: rtl/ldr_io_classify.sv
module ldr_io_classify
  import ldr_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic [ALIAS_W-1:LANE_W] io_word,
  input  logic [LANES-1:0]        lane_en,
  output io_hits_t                hits
);
  logic [LANES-1:0] mono_l;
  logic [LANES-1:0] tail_l;
  logic [LANES-1:0] colour_l;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [LANE_W-1:0] LANE_IDX = LANE_W'(g);
    logic [ALIAS_W-1:0] byte_a;
    logic               is_mono;
    logic               is_tail;
    logic               is_colour;

    always_comb begin
      byte_a    = {io_word, LANE_IDX};
      is_mono   = (byte_a == MONO_P0) || (byte_a == MONO_P1) ||
                  (byte_a == MONO_P2) || (byte_a == MONO_P3) ||
                  (byte_a == MONO_P4) || (byte_a == MONO_P5);
      is_tail   = (byte_a >= TAIL_LO) && (byte_a <= TAIL_HI);
      is_colour = ((byte_a >= CLR_A_LO) && (byte_a <= CLR_A_HI)) ||
                  ((byte_a >= CLR_B_LO) && (byte_a <= CLR_B_HI));
      mono_l[g]   = lane_en[g] && is_mono;
      tail_l[g]   = lane_en[g] && is_tail;
      colour_l[g] = lane_en[g] && is_colour;
    end
  end

  always_comb begin
    hits.mono   = |mono_l;
    hits.tail   = |tail_l;
    hits.colour = |colour_l;
  end
endmodule

// File: rtl/ldr_mem_classify.sv
module ldr_mem_classify
  import ldr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  output mem_hits_t         hits
);
  localparam logic [ADDR_W-1:0] FB_LO_W   = ADDR_W'(FB_LO);
  localparam logic [ADDR_W-1:0] FB_HI_W   = ADDR_W'(FB_HI);
  localparam logic [ADDR_W-1:0] MONO_LO_W = ADDR_W'(MONO_LO);
  localparam logic [ADDR_W-1:0] MONO_HI_W = ADDR_W'(MONO_HI);

  always_comb begin
    hits.frame = (addr >= FB_LO_W) && (addr <= FB_HI_W);
    hits.mono  = (addr >= MONO_LO_W) && (addr <= MONO_HI_W);
  end
endmodule

// File: rtl/ldr_io_window.sv
module ldr_io_window #(
  parameter int unsigned IO_ADDR_W = 16,
  parameter int unsigned LANE_W    = 2
) (
  input  logic [IO_ADDR_W-1:LANE_W] io_word,
  input  logic [IO_ADDR_W-1:0]      base,
  input  logic [IO_ADDR_W-1:0]      limit,
  input  logic                      isa_en,
  output logic                      hit
);
  logic [IO_ADDR_W-1:0] word_a;
  logic                 in_range;
  logic                 isa_alias;

  always_comb begin
    word_a    = {io_word, {LANE_W{1'b0}}};
    in_range  = (word_a >= base) && (word_a <= limit);
    isa_alias = isa_en && (|word_a[9:8]);
    hit       = in_range && !isa_alias;
  end
endmodule

// File: rtl/ldr_route_sel.sv
module ldr_route_sel
  import ldr_pkg::*;
(
  input  logic      is_io,
  input  logic      eff_vga,
  input  logic      eff_mono,
  input  io_hits_t  io_hits,
  input  mem_hits_t mem_hits,
  input  logic      win_hit,
  output port_e     port
);
  port_e io_port;
  port_e mem_port;

  always_comb begin
    if (!eff_vga) begin
      if (io_hits.mono || io_hits.colour) io_port = PORT_HUB;
      else if (win_hit)                   io_port = PORT_GFX;
      else                                io_port = PORT_HUB;
    end else if (io_hits.tail || (eff_mono && io_hits.mono)) begin
      io_port = PORT_HUB;
    end else if (io_hits.colour || win_hit) begin
      io_port = PORT_GFX;
    end else begin
      io_port = PORT_HUB;
    end
  end

  always_comb begin
    if (!mem_hits.frame || !eff_vga)     mem_port = PORT_HUB;
    else if (mem_hits.mono && eff_mono)  mem_port = PORT_HUB;
    else                                 mem_port = PORT_GFX;
  end

  assign port = is_io ? io_port : mem_port;
endmodule

// File: rtl/legacy_disp_router.sv
module legacy_disp_router
  import ldr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned IO_ADDR_W = 16,
  parameter int unsigned LANES     = 4,
  localparam int unsigned LANE_W   = $clog2(LANES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_is_io,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [LANES-1:0]     req_be,
  input  logic                 cfg_vga_en,
  input  logic                 cfg_mda_present,
  input  logic                 cfg_isa_en,
  input  logic [IO_ADDR_W-1:0] cfg_io_base,
  input  logic [IO_ADDR_W-1:0] cfg_io_limit,
  output logic                 rsp_valid,
  output logic                 rsp_to_gfx,
  output logic                 cfg_err
);
  io_hits_t  io_hits;
  mem_hits_t mem_hits;
  logic      win_hit;
  logic      eff_vga;
  logic      eff_mono;
  logic      bad_cfg;
  port_e     port_sel;

  logic valid_q, valid_d;
  logic gfx_q, gfx_d, gfx_en;
  logic err_q, err_d;

  always_comb begin
    bad_cfg  = !cfg_vga_en && cfg_mda_present;
    eff_vga  = cfg_vga_en;
    eff_mono = cfg_vga_en && cfg_mda_present;
  end

  ldr_io_classify #(.LANES(LANES)) u_io_cls (
    .io_word (req_addr[ALIAS_W-1:LANE_W]),
    .lane_en (req_be),
    .hits    (io_hits)
  );

  ldr_mem_classify #(.ADDR_W(ADDR_W)) u_mem_cls (
    .addr (req_addr),
    .hits (mem_hits)
  );

  ldr_io_window #(.IO_ADDR_W(IO_ADDR_W), .LANE_W(LANE_W)) u_win (
    .io_word (req_addr[IO_ADDR_W-1:LANE_W]),
    .base    (cfg_io_base),
    .limit   (cfg_io_limit),
    .isa_en  (cfg_isa_en),
    .hit     (win_hit)
  );

  ldr_route_sel u_sel (
    .is_io    (req_is_io),
    .eff_vga  (eff_vga),
    .eff_mono (eff_mono),
    .io_hits  (io_hits),
    .mem_hits (mem_hits),
    .win_hit  (win_hit),
    .port     (port_sel)
  );

  always_comb begin
    valid_d = req_valid;
    gfx_en  = req_valid;
    gfx_d   = (port_sel == PORT_GFX);
    err_d   = err_q || bad_cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      gfx_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (gfx_en) gfx_q <= gfx_d;
      err_q   <= err_d;
    end
  end

  assign rsp_valid  = valid_q;
  assign rsp_to_gfx = gfx_q;
  assign cfg_err    = err_q;
endmodule

// File: rtl/ldr_checker.sv
module ldr_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_is_io,
  input logic [ADDR_W-1:0] req_addr,
  input logic [LANES-1:0]  req_be,
  input logic              cfg_vga_en,
  input logic              cfg_mda_present,
  input logic              rsp_valid,
  input logic              rsp_to_gfx,
  input logic              cfg_err
);
  localparam logic [ADDR_W-1:0] A_FB_LO = ADDR_W'(32'h000A_0000);
  localparam logic [ADDR_W-1:0] A_FB_HI = ADDR_W'(32'h000B_FFFF);
  localparam logic [ADDR_W-1:0] A_CL_HI = ADDR_W'(32'h000A_FFFF);
  localparam logic [ADDR_W-1:0] A_MO_LO = ADDR_W'(32'h000B_0000);
  localparam logic [ADDR_W-1:0] A_MO_HI = ADDR_W'(32'h000B_7FFF);

  assert_valid_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_valid_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_port_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(rsp_to_gfx));
  assert_mono_mem_hub_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is_io && cfg_vga_en && cfg_mda_present &&
     req_addr >= A_MO_LO && req_addr <= A_MO_HI) |=> !rsp_to_gfx);
  assert_colour_mem_gfx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is_io && cfg_vga_en &&
     req_addr >= A_FB_LO && req_addr <= A_CL_HI) |=> rsp_to_gfx);
  assert_other_mem_hub_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is_io && (req_addr < A_FB_LO || req_addr > A_FB_HI))
    |=> !rsp_to_gfx);
  assert_tail_io_hub_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_io && cfg_vga_en && req_addr[9:2] == 8'hEF && |req_be)
    |=> !rsp_to_gfx);
  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  assert_err_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_vga_en && cfg_mda_present) |=> cfg_err);
endmodule

bind legacy_disp_router ldr_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .req_is_io       (req_is_io),
  .req_addr        (req_addr),
  .req_be          (req_be),
  .cfg_vga_en      (cfg_vga_en),
  .cfg_mda_present (cfg_mda_present),
  .rsp_valid       (rsp_valid),
  .rsp_to_gfx      (rsp_to_gfx),
  .cfg_err         (cfg_err)
);

// File: tb/legacy_disp_router_test.sv
module legacy_disp_router_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_is_io;
  logic [31:0] req_addr;
  logic [3:0]  req_be;
  logic        cfg_vga_en, cfg_mda_present, cfg_isa_en;
  logic [15:0] cfg_io_base, cfg_io_limit;
  logic        rsp_valid, rsp_to_gfx, cfg_err;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  typedef struct { logic gfx; string tag; } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  legacy_disp_router uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_io(req_is_io),
    .req_addr(req_addr), .req_be(req_be), .cfg_vga_en(cfg_vga_en),
    .cfg_mda_present(cfg_mda_present), .cfg_isa_en(cfg_isa_en),
    .cfg_io_base(cfg_io_base), .cfg_io_limit(cfg_io_limit),
    .rsp_valid(rsp_valid), .rsp_to_gfx(rsp_to_gfx), .cfg_err(cfg_err)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        chk(1'b1, 1'b0, "R1 response with nothing outstanding");
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(rsp_to_gfx, e.gfx, e.tag);
      end
    end
  end

  task automatic send(input logic io, input logic [31:0] a, input logic [3:0] be,
                      input logic gfx, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_is_io = io; req_addr = a; req_be = be;
    sb.push_back('{gfx, tag});
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic set_cfg(input logic v, input logic m, input logic i,
                         input logic [15:0] b, input logic [15:0] l);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_vga_en = v; cfg_mda_present = m; cfg_isa_en = i;
    cfg_io_base = b; cfg_io_limit = l;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      failures++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_is_io = 1'b0; req_addr = '0; req_be = '0;
    cfg_vga_en = 1'b0; cfg_mda_present = 1'b0; cfg_isa_en = 1'b0;
    cfg_io_base = '0; cfg_io_limit = '0;
    repeat (3) @(negedge clk);
    chk(rsp_valid, 1'b0, "R2 reset rsp_valid");
    chk(rsp_to_gfx, 1'b0, "R2 reset rsp_to_gfx");
    chk(cfg_err, 1'b0, "R2 reset cfg_err");
    rst_n = 1'b1;

    // both bits set, window 1000h-1FFFh
    set_cfg(1'b1, 1'b1, 1'b0, 16'h1000, 16'h1FFF);
    send(1'b0, 32'h000B_0000, 4'h0, 1'b0, "R3 mono mem low both set");
    send(1'b0, 32'h000B_7FFC, 4'h0, 1'b0, "R3 mono mem top both set");
    send(1'b0, 32'h000A_0000, 4'h0, 1'b1, "R4 colour mem A0000");
    send(1'b0, 32'h000B_8000, 4'h0, 1'b1, "R4 colour mem B8000");
    send(1'b0, 32'h000C_0000, 4'h0, 1'b0, "R5 mem C0000");
    send(1'b0, 32'h0009_FFFC, 4'h0, 1'b0, "R5 mem below frame");
    send(1'b1, 32'h0000_03B4, 4'b0001, 1'b0, "R6 io 3B4 lane0");
    send(1'b1, 32'h0000_03B4, 4'b1000, 1'b1, "R8 io 3B7 lane3 colour");
    send(1'b1, 32'h0000_03B4, 4'b1111, 1'b0, "R6 io 3B4 all lanes straddle");
    send(1'b1, 32'h0000_FFB8, 4'b0001, 1'b0, "R6 io alias FFB8");
    send(1'b1, 32'h0000_03BC, 4'b0001, 1'b0, "R7 io 3BC both set");
    send(1'b1, 32'h0000_1234, 4'b1111, 1'b1, "R10 io 1234 in window");
    send(1'b1, 32'h0000_2000, 4'b1111, 1'b0, "R10 io 2000 outside window");
    send(1'b1, 32'h0000_03C0, 4'b1111, 1'b1, "R8 io 3C0");
    idle();
    idle();
    chk(rsp_valid, 1'b0, "R1 no response when idle");
    chk(rsp_to_gfx, 1'b1, "R1 port select held");

    // display enable only
    set_cfg(1'b1, 1'b0, 1'b0, 16'h1000, 16'h1FFF);
    send(1'b0, 32'h000B_0000, 4'h0, 1'b1, "R3 mono mem display only");
    send(1'b1, 32'h0000_03B4, 4'b0001, 1'b1, "R8 io 3B4 display only");
    send(1'b1, 32'h0000_03BC, 4'b0100, 1'b0, "R7 io 3BE display only");
    send(1'b1, 32'h0000_07BC, 4'b1000, 1'b0, "R7 io alias 7BF display only");
    idle();

    // both clear, ISA filter, full window
    set_cfg(1'b0, 1'b0, 1'b1, 16'h0000, 16'hFFFF);
    send(1'b0, 32'h000A_0000, 4'h0, 1'b0, "R4 colour mem display off");
    send(1'b0, 32'h000B_0000, 4'h0, 1'b0, "R3 mono mem display off");
    send(1'b1, 32'h0000_03C0, 4'b0001, 1'b0, "R9 io 3C0 display off");
    send(1'b1, 32'h0000_0080, 4'b1111, 1'b1, "R10 io 0080 isa in window");
    send(1'b1, 32'h0000_0180, 4'b1111, 1'b0, "R10 io 0180 isa excluded");
    idle();
    set_cfg(1'b0, 1'b0, 1'b0, 16'h0000, 16'hFFFF);
    send(1'b1, 32'h0000_03BC, 4'b0001, 1'b1, "R9 io 3BC window display off");
    idle();
    chk(cfg_err, 1'b0, "R11 no error before bad setting");

    // unsupported setting
    set_cfg(1'b0, 1'b1, 1'b0, 16'h0000, 16'hFFFF);
    send(1'b0, 32'h000B_0000, 4'h0, 1'b0, "R11 mono mem bad setting");
    chk(cfg_err, 1'b1, "R11 error raised");
    send(1'b1, 32'h0000_03B4, 4'b0001, 1'b0, "R11 io 3B4 bad setting");
    send(1'b1, 32'h0000_0080, 4'b0001, 1'b1, "R11 io window bad setting");
    idle();
    set_cfg(1'b1, 1'b1, 1'b0, 16'h0000, 16'hFFFF);
    idle();
    idle();
    chk(cfg_err, 1'b1, "R11 error sticky");
    chk(sb.size() == 0, 1'b1, "R1 all responses seen");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule